// File: doc/BRIEF.md
# Operand Effective Address Unit

This block works out the 16-bit memory address that an 8-bit processor instruction's operand refers to. The decoder hands it a mode code, the operand bytes and the two index register values, then pulses `start`. Direct modes need no memory access, and the address appears one cycle later. The indirect modes need a 2-byte pointer from memory. For these the block reads the two bytes in turn over a simple request/ready port, waits as long as memory takes, and then builds the result. When an instruction has no memory operand, the block still signals completion and raises a flag.

There are two indexed indirect forms, and they differ in where the index add happens. The pre-indexed form adds X to the page-zero operand before the pointer is read. The post-indexed form reads the pointer at the operand first and then adds Y to it. A third indirect form, used for jumps, reads its target from a full 16-bit address and the address after it. Pointers are little-endian: the low byte is read first, from the lower address.

Top module: `ea_unit`

## Requirements
- R1: Mode codes are 0 none, 1 page-zero, 2 page-zero+X, 3 page-zero+Y, 4 absolute, 5 absolute+X, 6 absolute+Y, 7 pre-indexed indirect, 8 post-indexed indirect and 9 jump indirect. Codes 0 and 10 to 15 raise `done` with `no_mem`=1 and `ea`=0 in the cycle after `start`, and issue no memory request.
- R2: Page-zero modes give `ea` = {8'h00, (op_lo + idx) mod 256}, where idx is 0, X or Y. `done` rises in the cycle after `start` and `no_mem` stays 0.
- R3: Absolute modes give `ea` = ({op_hi,op_lo} + idx) mod 65536, where idx is 0, X or Y. `done` rises in the cycle after `start` and `no_mem` stays 0.
- R4: Pre-indexed indirect reads the low pointer byte at (op_lo+X) mod 256 and then the high byte at (op_lo+X+1) mod 256, both in page zero. `ea` equals that pointer.
- R5: Post-indexed indirect reads the low byte at op_lo and then the high byte at (op_lo+1) mod 256, both in page zero. `ea` = (pointer + Y) mod 65536.
- R6: Jump indirect reads the low byte at {op_hi,op_lo} and then the high byte at ({op_hi,op_lo}+1) mod 65536. `ea` equals that pointer.
- R7: `mem_req` stays high with `mem_addr` unchanged until `mem_ready` is seen high. A byte is taken on a clock edge where both are high. `done` rises in the cycle after the second byte is taken, and never while a request is open.
- R8: A `start` that arrives while pointer bytes are being fetched is ignored. The fetch in progress finishes with its own result.
- R9: While reset is asserted, `done`, `no_mem` and `mem_req` are low and `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for the presented operand |
| mode | input | 4 | Addressing mode code (see R1) |
| op_lo | input | 8 | Low operand byte |
| op_hi | input | 8 | High operand byte |
| reg_x | input | 8 | X index value |
| reg_y | input | 8 | Y index value |
| mem_addr | output | 16 | Pointer byte read address |
| mem_req | output | 1 | Pointer byte read request |
| mem_ready | input | 1 | Memory has the read byte on mem_rdata |
| mem_rdata | input | 8 | Read byte |
| ea | output | 16 | Effective address, valid with done |
| done | output | 1 | One-cycle completion strobe |
| no_mem | output | 1 | The finished operand has no memory address |

## Verification
Every mode code is swept over all 256 low operand values. The index values and high byte change with each step, so the runs cover carries that wrap inside page zero, carries across pages and carries out of the top of the address space. Each run compares the read addresses it sees against expected ones, and this shows whether the index was added before the pointer fetch or after it. The memory model fills each byte with a value derived from its own address, so a swapped low and high byte, or a byte read from the wrong address, gives a wrong result. The memory latency changes from run to run, which tests holding the request open and the timing of `done`. A stray `start` is injected during a fetch to show that an open fetch cannot be interrupted.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      M_NONE = 4'd0,
      M_ZP   = 4'd1,
      M_ZPX  = 4'd2,
      M_ZPY  = 4'd3,
      M_ABS  = 4'd4,
      M_ABSX = 4'd5,
      M_ABSY = 4'd6,
      M_INDX = 4'd7,
      M_INDY = 4'd8,
      M_JIND = 4'd9
   } ea_mode_e;

   typedef enum logic [1:0] {
      F_IDLE = 2'd0,
      F_LO   = 2'd1,
      F_HI   = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter bit PAGE_WRAP = 1'b0
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] idx,
   output logic [AW-1:0] sum
);
   localparam int HW = AW - DW;

   generate
      if (PAGE_WRAP) begin : g_page
         logic [DW-1:0] low_sum;
         assign low_sum = base[DW-1:0] + idx;
         assign sum     = {{HW{1'b0}}, low_sum};
      end else begin : g_full
         assign sum = base + {{HW{1'b0}}, idx};
      end
   endgenerate
endmodule

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
   import ea_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [AW-1:0]     operand,
   input  logic [DW-1:0]     rx,
   input  logic [DW-1:0]     ry,
   output logic [AW-1:0]     direct_ea,
   output logic [AW-1:0]     ptr_base,
   output logic              is_none,
   output logic              is_indirect,
   output logic              ptr_page0
);
   localparam int HW = AW - DW;

   logic [DW-1:0] idx;
   logic [AW-1:0] zp_base;
   logic [AW-1:0] zp_sum;
   logic [AW-1:0] abs_sum;

   assign zp_base = {{HW{1'b0}}, operand[DW-1:0]};

   always_comb begin
      case (mode)
         M_ZPX, M_ABSX, M_INDX: idx = rx;
         M_ZPY, M_ABSY:         idx = ry;
         default:               idx = '0;
      endcase
   end

   ea_index_add #(.AW(AW), .DW(DW), .PAGE_WRAP(1'b1)) u_zp_add (
      .base (zp_base),
      .idx  (idx),
      .sum  (zp_sum)
   );

   ea_index_add #(.AW(AW), .DW(DW), .PAGE_WRAP(1'b0)) u_abs_add (
      .base (operand),
      .idx  (idx),
      .sum  (abs_sum)
   );

   always_comb begin
      direct_ea   = '0;
      ptr_base    = '0;
      is_none     = 1'b0;
      is_indirect = 1'b0;
      ptr_page0   = 1'b0;
      case (mode)
         M_ZP, M_ZPX, M_ZPY:    direct_ea = zp_sum;
         M_ABS, M_ABSX, M_ABSY: direct_ea = abs_sum;
         M_INDX: begin
            is_indirect = 1'b1;
            ptr_base    = zp_sum;
            ptr_page0   = 1'b1;
         end
         M_INDY: begin
            is_indirect = 1'b1;
            ptr_base    = zp_base;
            ptr_page0   = 1'b1;
         end
         M_JIND: begin
            is_indirect = 1'b1;
            ptr_base    = operand;
         end
         default: is_none = 1'b1;
      endcase
   end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
   import ea_pkg::*;
#(
   parameter int AW            = 16,
   parameter int DW            = 8,
   parameter bit JMP_PAGE_WRAP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] base_addr,
   input  logic          page0,
   output logic [AW-1:0] mem_addr,
   output logic          mem_req,
   input  logic          mem_ready,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic [AW-1:0] ptr,
   output logic          ptr_valid
);
   fetch_state_e  state;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] next_addr;
   logic [AW-1:0] next_full;
   logic [AW-1:0] next_wrap;
   logic [DW-1:0] lo_q;
   logic          page0_q;

   assign next_full = addr_q + {{(AW-1){1'b0}}, 1'b1};
   assign next_wrap = {addr_q[AW-1:DW], addr_q[DW-1:0] + {{(DW-1){1'b0}}, 1'b1}};

   generate
      if (JMP_PAGE_WRAP) begin : g_always_wrap
         assign next_addr = next_wrap;
      end else begin : g_select_wrap
         assign next_addr = page0_q ? next_wrap : next_full;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= F_IDLE;
         addr_q  <= '0;
         lo_q    <= '0;
         page0_q <= 1'b0;
      end else begin
         case (state)
            F_IDLE: begin
               if (launch) begin
                  addr_q  <= base_addr;
                  page0_q <= page0;
                  state   <= F_LO;
               end
            end
            F_LO: begin
               if (mem_ready) begin
                  lo_q   <= mem_rdata;
                  addr_q <= next_addr;
                  state  <= F_HI;
               end
            end
            F_HI: begin
               if (mem_ready) state <= F_IDLE;
            end
            default: state <= F_IDLE;
         endcase
      end
   end

   assign mem_req   = (state != F_IDLE);
   assign mem_addr  = addr_q;
   assign busy      = (state != F_IDLE);
   assign ptr_valid = (state == F_HI) && mem_ready;
   assign ptr       = {mem_rdata, lo_q};
endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int AW            = 16,
   parameter int DW            = 8,
   parameter bit JMP_PAGE_WRAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic [DW-1:0]     op_lo,
   input  logic [DW-1:0]     op_hi,
   input  logic [DW-1:0]     reg_x,
   input  logic [DW-1:0]     reg_y,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_req,
   input  logic              mem_ready,
   input  logic [DW-1:0]     mem_rdata,
   output logic [AW-1:0]     ea,
   output logic              done,
   output logic              no_mem
);
   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("ea_unit: AW must be twice DW");
      end
      if (DW < 2) begin : g_bad_data
         $error("ea_unit: DW must be at least 2");
      end
   endgenerate

   logic [AW-1:0]     direct_ea;
   logic [AW-1:0]     ptr_base;
   logic              is_none;
   logic              is_indirect;
   logic              ptr_page0;
   logic              busy;
   logic              accept;
   logic              launch;
   logic [AW-1:0]     ptr;
   logic              ptr_valid;
   logic [AW-1:0]     ptr_ea;
   logic [DW-1:0]     fin_idx;
   logic [MODE_W-1:0] mode_q;
   logic [DW-1:0]     y_q;
   logic [AW-1:0]     ea_q;
   logic              done_q;
   logic              no_mem_q;

   ea_direct_calc #(.AW(AW), .DW(DW)) u_direct (
      .mode        (mode),
      .operand     ({op_hi, op_lo}),
      .rx          (reg_x),
      .ry          (reg_y),
      .direct_ea   (direct_ea),
      .ptr_base    (ptr_base),
      .is_none     (is_none),
      .is_indirect (is_indirect),
      .ptr_page0   (ptr_page0)
   );

   assign accept = start && !busy;
   assign launch = accept && is_indirect;

   ea_ptr_fetch #(.AW(AW), .DW(DW), .JMP_PAGE_WRAP(JMP_PAGE_WRAP)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .base_addr (ptr_base),
      .page0     (ptr_page0),
      .mem_addr  (mem_addr),
      .mem_req   (mem_req),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .ptr       (ptr),
      .ptr_valid (ptr_valid)
   );

   assign fin_idx = (mode_q == M_INDY) ? y_q : '0;

   ea_index_add #(.AW(AW), .DW(DW), .PAGE_WRAP(1'b0)) u_post_add (
      .base (ptr),
      .idx  (fin_idx),
      .sum  (ptr_ea)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         y_q      <= '0;
         ea_q     <= '0;
         done_q   <= 1'b0;
         no_mem_q <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         no_mem_q <= 1'b0;
         if (accept) begin
            mode_q <= mode;
            y_q    <= reg_y;
            if (!is_indirect) begin
               done_q   <= 1'b1;
               no_mem_q <= is_none;
               ea_q     <= is_none ? '0 : direct_ea;
            end
         end
         if (ptr_valid) begin
            done_q <= 1'b1;
            ea_q   <= ptr_ea;
         end
      end
   end

   assign ea     = ea_q;
   assign done   = done_q;
   assign no_mem = no_mem_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
   import ea_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [MODE_W-1:0] mode,
   input logic              busy,
   input logic [MODE_W-1:0] mode_q,
   input logic              mem_req,
   input logic              mem_ready,
   input logic [AW-1:0]     mem_addr,
   input logic              done,
   input logic              no_mem,
   input logic [AW-1:0]     ea
);
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   assert_done_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   assert_none_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      no_mem |-> (done && ea == '0));

   assert_zp_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (mode == M_ZP || mode == M_ZPX || mode == M_ZPY))
      |=> (done && !no_mem && ea[AW-1:DW] == '0));

   // R4 and R5: pointer bytes of the page-zero indirect forms stay in page zero
   assert_ptr_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (mode_q == M_INDX || mode_q == M_INDY)) |-> (mem_addr[AW-1:DW] == '0));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(mode_q));
endmodule

bind ea_unit ea_unit_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .busy      (busy),
   .mode_q    (mode_q),
   .mem_req   (mem_req),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .done      (done),
   .no_mem    (no_mem),
   .ea        (ea)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = 4'd0;
   logic [7:0]  op_lo = 8'd0;
   logic [7:0]  op_hi = 8'd0;
   logic [7:0]  reg_x = 8'd0;
   logic [7:0]  reg_y = 8'd0;
   logic [15:0] mem_addr;
   logic        mem_req;
   logic        mem_ready = 1'b0;
   logic [7:0]  mem_rdata = 8'd0;
   logic [15:0] ea;
   logic        done;
   logic        no_mem;

   always #10 clk = ~clk;

   ea_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_lo(op_lo), .op_hi(op_hi), .reg_x(reg_x), .reg_y(reg_y),
      .mem_addr(mem_addr), .mem_req(mem_req), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .ea(ea), .done(done), .no_mem(no_mem)
   );

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wait_cnt = 0;
   int nlog = 0;
   int req_drop = 0;
   bit finished = 0;
   logic [15:0] log_addr [0:3];

   function automatic logic [7:0] memf(input logic [15:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd7;
      return m ^ a[15:8] ^ 8'h5A;
   endfunction

   // memory model: responds lat cycles after a request, then drops ready for a cycle
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ready = 1'b0;
         wait_cnt  = 0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
         wait_cnt  = 0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_ready = 1'b1;
            mem_rdata = memf(mem_addr);
            if (nlog < 4) log_addr[nlog] = mem_addr;
            nlog++;
         end else begin
            wait_cnt++;
         end
      end else if (wait_cnt != 0) begin
         req_drop++;
         wait_cnt = 0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                      input logic [7:0] x, input logic [7:0] y,
                      output logic [15:0] ea_o, output logic nm_o, output int cyc);
      @(negedge clk);
      mode = m; op_lo = lo; op_hi = hi; reg_x = x; reg_y = y;
      start = 1'b1;
      nlog = 0;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      ea_o = ea;
      nm_o = no_mem;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] r_ea;
      logic        r_nm;
      int          cyc;
      logic [15:0] exp_ea;
      logic [15:0] a0, a1, p;
      logic [7:0]  x, y, hi;

      repeat (3) @(negedge clk);
      chk("R9 done in reset", {31'd0, done}, 0);
      chk("R9 mem_req in reset", {31'd0, mem_req}, 0);
      chk("R9 no_mem in reset", {31'd0, no_mem}, 0);
      chk("R9 ea in reset", {16'd0, ea}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: no-operand codes
      for (int m = 0; m < 16; m++) begin
         if (m >= 1 && m <= 9) continue;
         run(4'(m), 8'h33, 8'h44, 8'h01, 8'h02, r_ea, r_nm, cyc);
         chk("R1 no_mem flag", {31'd0, r_nm}, 1);
         chk("R1 ea zero", {16'd0, r_ea}, 0);
         chk("R1 no memory read", nlog, 0);
         chk("R1 done latency", cyc, 1);
      end

      // R2 and R3: direct modes over all low operand values
      for (int v = 0; v < 256; v++) begin
         x  = 8'(v * 5 + 3);
         y  = 8'(v * 11 + 1);
         hi = 8'(v) ^ 8'hA5;
         for (int m = 1; m <= 6; m++) begin
            case (m)
               1: exp_ea = {8'h00, 8'(v)};
               2: exp_ea = {8'h00, 8'(v + x)};
               3: exp_ea = {8'h00, 8'(v + y)};
               4: exp_ea = {hi, 8'(v)};
               5: exp_ea = 16'({hi, 8'(v)} + x);
               default: exp_ea = 16'({hi, 8'(v)} + y);
            endcase
            run(4'(m), 8'(v), hi, x, y, r_ea, r_nm, cyc);
            if (m <= 3) begin
               chk("R2 page-zero ea", {16'd0, r_ea}, {16'd0, exp_ea});
               chk("R2 latency", cyc, 1);
            end else begin
               chk("R3 absolute ea", {16'd0, r_ea}, {16'd0, exp_ea});
               chk("R3 latency", cyc, 1);
            end
            if (r_nm !== 1'b0 || nlog != 0) chk("R2 R3 no read, no flag", {31'd0, r_nm} + nlog, 0);
         end
      end

      // R4, R5, R6, R7: indirect modes with varying memory latency
      for (int v = 0; v < 256; v++) begin
         x   = 8'(v * 13 + 7);
         y   = 8'(v * 3 + 250);
         hi  = 8'(v) ^ 8'hA5;
         lat = v % 3;
         for (int m = 7; m <= 9; m++) begin
            case (m)
               7: begin a0 = {8'h00, 8'(v + x)}; a1 = {8'h00, 8'(v + x + 1)}; end
               8: begin a0 = {8'h00, 8'(v)};     a1 = {8'h00, 8'(v + 1)}; end
               default: begin a0 = {hi, 8'(v)}; a1 = 16'({hi, 8'(v)} + 1); end
            endcase
            p = {memf(a1), memf(a0)};
            exp_ea = (m == 8) ? 16'(p + y) : p;
            run(4'(m), 8'(v), hi, x, y, r_ea, r_nm, cyc);
            if (m == 7) begin
               chk("R4 low byte address", {16'd0, log_addr[0]}, {16'd0, a0});
               chk("R4 high byte address", {16'd0, log_addr[1]}, {16'd0, a1});
               chk("R4 pointer ea", {16'd0, r_ea}, {16'd0, exp_ea});
            end else if (m == 8) begin
               chk("R5 low byte address", {16'd0, log_addr[0]}, {16'd0, a0});
               chk("R5 high byte address", {16'd0, log_addr[1]}, {16'd0, a1});
               chk("R5 pointer plus Y", {16'd0, r_ea}, {16'd0, exp_ea});
            end else begin
               chk("R6 low byte address", {16'd0, log_addr[0]}, {16'd0, a0});
               chk("R6 high byte address", {16'd0, log_addr[1]}, {16'd0, a1});
               chk("R6 jump target", {16'd0, r_ea}, {16'd0, exp_ea});
            end
            chk("R7 read count", nlog, 2);
            chk("R7 done latency", cyc, 4 + 2 * lat);
            if (r_nm !== 1'b0) chk("R7 no_mem low", {31'd0, r_nm}, 0);
         end
      end

      // R6 vector-style pointer at the top of memory
      lat = 1;
      run(4'd9, 8'hFC, 8'hFF, 8'h00, 8'h00, r_ea, r_nm, cyc);
      chk("R6 top-of-memory target", {16'd0, r_ea}, {16'd0, memf(16'hFFFD), memf(16'hFFFC)});

      // R8: start during an open fetch is ignored
      lat = 2;
      @(negedge clk);
      mode = 4'd7; op_lo = 8'hF0; op_hi = 8'h12; reg_x = 8'h20; reg_y = 8'h00;
      start = 1'b1;
      nlog = 0;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      mode = 4'd4; op_lo = 8'h99; op_hi = 8'h88; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 3;
      while (!done && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      chk("R8 result from first request", {16'd0, ea}, {16'd0, memf(16'h0011), memf(16'h0010)});
      chk("R8 read count", nlog, 2);
      chk("R8 done latency", cyc, 4 + 2 * lat);
      @(negedge clk);
      chk("R8 no second done", {31'd0, done}, 0);

      chk("R7 request held until ready", req_drop, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule